// File: doc/BRIEF.md
# Floating-Point Significand Rounding Stage

This block takes an unrounded single-precision significand and makes the final rounding decision. Its inputs are the 24-bit significand with the hidden bit present, three extra bits from below it (guard, round, sticky), the sign of the result, a 2-bit rounding mode, and a flag that says whether the significand still needs a one-position left shift to normalize. It returns the rounded 24-bit significand, an exponent-adjust flag that is raised when the rounding increment carries out of the significand, and an inexact flag. Alignment, the significand adder, exponent arithmetic, overflow to infinity and subnormal handling all happen elsewhere.

The extra bits are first remapped for the normalization case. The result is a kept significand plus three effective bits: the last kept bit (L), the round bit (R) and the sticky bit (S). A mode decoder turns L, R, S and the sign into a single increment decision, and an incrementer adds one unit in the last place. Results are registered. A two-state output controller has the states `ST_EMPTY` and `ST_FULL`. The transition `take` goes to `ST_FULL` on a cycle with `in_valid` high. The transition `drain` goes back to `ST_EMPTY` on a cycle with `in_valid` low. `out_valid` is high exactly in `ST_FULL`.

Top module: `fp_round_unit`

## Requirements
- R1: Mode code 00 is round-to-nearest-even. One ulp is added exactly when R AND (S OR L) is 1. A tie (R=1, S=0) rounds up only when L=1.
- R2: Mode code 01 is round toward zero. It never adds an ulp, and the kept significand passes through unchanged.
- R3: Mode code 10 is round toward +infinity. One ulp is added only when the sign input is 0 and R OR S is 1.
- R4: Mode code 11 is round toward -infinity. One ulp is added only when the sign input is 1 and R OR S is 1.
- R5: With `in_norm_shift`=0, the kept significand is `in_sig` and L is `in_sig[0]`. R is the incoming guard bit, and S is incoming round OR incoming sticky.
- R6: With `in_norm_shift`=1, the kept significand is `{in_sig[22:0], guard}`, so the guard bit becomes L. R is the incoming round bit and S is the incoming sticky bit.
- R7: `out_inexact` is the effective R OR S, in every mode. In nearest mode with R=0 there is no increment, and S alone sets inexact.
- R8: If the increment carries out of bit 23, `out_sig` becomes 0x800000 and `out_exp_adj` is 1. Otherwise `out_exp_adj` is 0.
- R9: After reset, `out_valid` is 0 and `out_sig` is 0. The result for an input accepted with `in_valid`=1 appears with `out_valid`=1 on the next clock edge. A cycle with `in_valid`=0 gives `out_valid`=0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item present this cycle |
| in_sig | input | 24 | Unrounded significand, hidden bit at bit 23 |
| in_guard | input | 1 | First bit below the significand |
| in_round | input | 1 | Second bit below the significand |
| in_sticky | input | 1 | OR of all lower bits |
| in_sign | input | 1 | Result sign, 1 = negative |
| in_mode | input | 2 | Rounding mode code |
| in_norm_shift | input | 1 | 1 = one-position left normalization needed |
| out_valid | output | 1 | Registered result valid |
| out_sig | output | 24 | Rounded significand |
| out_exp_adj | output | 1 | Increment carried out; exponent must be raised by one |
| out_inexact | output | 1 | Discarded bits were not all zero |

## Verification
The normalization remap and the carry-out of the increment can both act on one item. This happens when `in_norm_shift`=1 and the shifted-in guard bit completes a significand of all ones. The stimulus for that case uses 0x7FFFFF with guard, round and sticky all set in nearest mode. The expected result is 0x800000 with both the exponent-adjust and inexact flags raised. The scoreboard also sends back-to-back items and items separated by idle cycles, so each result is checked in the cycle right after its input.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } round_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

    typedef struct packed {
        logic lsb;
        logic rnd;
        logic stk;
    } rbits_t;

endpackage

// File: rtl/fpr_remap.sv
module fpr_remap
    import fpr_pkg::*;
#(
    parameter int SIG_W = 24
) (
    input  logic [SIG_W-1:0] sig,
    input  logic             guard,
    input  logic             rnd,
    input  logic             sticky,
    input  logic             norm_shift,
    output logic [SIG_W-1:0] kept,
    output rbits_t           bits
);

    logic [SIG_W-1:0] kept_shifted;
    logic [SIG_W-1:0] kept_plain;

    assign kept_shifted = {sig[SIG_W-2:0], guard};
    assign kept_plain   = sig;

    always_comb begin
        if (norm_shift) begin
            kept     = kept_shifted;
            bits.rnd = rnd;
            bits.stk = sticky;
        end else begin
            kept     = kept_plain;
            bits.rnd = guard;
            bits.stk = rnd | sticky;
        end
        bits.lsb = kept[0];
    end

endmodule

// File: rtl/fpr_decide.sv
module fpr_decide
    import fpr_pkg::*;
(
    input  round_mode_e mode,
    input  logic        sign,
    input  rbits_t      bits,
    output logic        inc,
    output logic        inexact
);

    logic lost;

    assign lost = bits.rnd | bits.stk;

    always_comb begin
        unique case (mode)
            RM_NEAR_EVEN: inc = bits.rnd & (bits.stk | bits.lsb);
            RM_TO_ZERO:   inc = 1'b0;
            RM_TO_POS:    inc = ~sign & lost;
            RM_TO_NEG:    inc = sign & lost;
        endcase
    end

    assign inexact = lost;

endmodule

// File: rtl/fpr_incr.sv
module fpr_incr #(
    parameter int SIG_W = 24
) (
    input  logic [SIG_W-1:0] kept,
    input  logic             inc,
    output logic [SIG_W-1:0] sig_out,
    output logic             carry
);

    localparam logic [SIG_W-1:0] ONE_POINT_ZERO = {1'b1, {(SIG_W-1){1'b0}}};

    logic [SIG_W:0] sum;

    assign sum   = {1'b0, kept} + {{SIG_W{1'b0}}, inc};
    assign carry = sum[SIG_W];

    always_comb begin
        if (carry) begin
            sig_out = ONE_POINT_ZERO;
        end else begin
            sig_out = sum[SIG_W-1:0];
        end
    end

endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
    import fpr_pkg::*;
#(
    parameter int SIG_W = 24,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SIG_W-1:0]  in_sig,
    input  logic              in_guard,
    input  logic              in_round,
    input  logic              in_sticky,
    input  logic              in_sign,
    input  logic [MODE_W-1:0] in_mode,
    input  logic              in_norm_shift,
    output logic              out_valid,
    output logic [SIG_W-1:0]  out_sig,
    output logic              out_exp_adj,
    output logic              out_inexact
);

    out_state_e       state_q;
    out_state_e       state_d;

    logic [SIG_W-1:0] kept;
    rbits_t           bits;
    logic             inc;
    logic             inexact;
    logic [SIG_W-1:0] rounded;
    logic             carry;
    round_mode_e      mode;

    assign mode = round_mode_e'(in_mode);

    fpr_remap #(.SIG_W(SIG_W)) u_remap (
        .sig        (in_sig),
        .guard      (in_guard),
        .rnd        (in_round),
        .sticky     (in_sticky),
        .norm_shift (in_norm_shift),
        .kept       (kept),
        .bits       (bits)
    );

    fpr_decide u_decide (
        .mode    (mode),
        .sign    (in_sign),
        .bits    (bits),
        .inc     (inc),
        .inexact (inexact)
    );

    fpr_incr #(.SIG_W(SIG_W)) u_incr (
        .kept    (kept),
        .inc     (inc),
        .sig_out (rounded),
        .carry   (carry)
    );

    // next state: take / drain
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sig     <= '0;
            out_exp_adj <= 1'b0;
            out_inexact <= 1'b0;
        end else if (in_valid) begin
            out_sig     <= rounded;
            out_exp_adj <= carry;
            out_inexact <= inexact;
        end
    end

    assign out_valid = (state_q == ST_FULL);

endmodule

// File: rtl/fp_round_unit_chk.sv
module fp_round_unit_chk
    import fpr_pkg::*;
#(
    parameter int SIG_W = 24,
    parameter int MODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [SIG_W-1:0]  in_sig,
    input logic              in_guard,
    input logic              in_round,
    input logic              in_sticky,
    input logic              in_sign,
    input logic [MODE_W-1:0] in_mode,
    input logic              in_norm_shift,
    input logic              out_valid,
    input logic [SIG_W-1:0]  out_sig,
    input logic              out_exp_adj,
    input logic              out_inexact
);

    localparam logic [SIG_W-1:0] ONE_POINT_ZERO = {1'b1, {(SIG_W-1){1'b0}}};

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_truncate_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == RM_TO_ZERO && !in_norm_shift)
        |=> (out_sig == $past(in_sig) && !out_exp_adj));

    a_r3_pos_neg_sign_no_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == RM_TO_POS && in_sign && !in_norm_shift)
        |=> (out_sig == $past(in_sig)));

    a_r4_neg_pos_sign_no_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == RM_TO_NEG && !in_sign && !in_norm_shift)
        |=> (out_sig == $past(in_sig)));

    a_r7_inexact_unshifted: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_norm_shift)
        |=> (out_inexact == ($past(in_guard) | $past(in_round) | $past(in_sticky))));

    a_r6_inexact_shifted: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_norm_shift)
        |=> (out_inexact == ($past(in_round) | $past(in_sticky))));

    a_r8_carry_result: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_exp_adj) |-> (out_sig == ONE_POINT_ZERO));

    a_r5_exact_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_norm_shift && !in_guard && !in_round && !in_sticky)
        |=> (out_sig == $past(in_sig) && !out_inexact && !out_exp_adj));

endmodule

bind fp_round_unit fp_round_unit_chk #(.SIG_W(SIG_W), .MODE_W(MODE_W)) u_chk (.*);

// File: tb/fp_round_unit_bench.sv
`timescale 1ns/1ps
module fp_round_unit_bench;

    localparam int W = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_sig = '0;
    logic          in_guard = 1'b0;
    logic          in_round = 1'b0;
    logic          in_sticky = 1'b0;
    logic          in_sign = 1'b0;
    logic [1:0]    in_mode = 2'b00;
    logic          in_norm_shift = 1'b0;
    logic          out_valid;
    logic [W-1:0]  out_sig;
    logic          out_exp_adj;
    logic          out_inexact;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [W-1:0] sig;
        logic         adj;
        logic         inx;
        string        tag;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    fp_round_unit u_fp_round_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sig(in_sig),
        .in_guard(in_guard), .in_round(in_round), .in_sticky(in_sticky),
        .in_sign(in_sign), .in_mode(in_mode), .in_norm_shift(in_norm_shift),
        .out_valid(out_valid), .out_sig(out_sig), .out_exp_adj(out_exp_adj),
        .out_inexact(out_inexact)
    );

    // Reference from the requirements
    function automatic exp_t model(logic [W-1:0] s, logic g, logic r, logic k,
                                   logic neg, logic [1:0] m, logic sh, string tag);
        exp_t e;
        logic [W-1:0] kp;
        logic L, R, S, up;
        logic [W:0] t;
        if (sh) begin kp = {s[W-2:0], g}; R = r; S = k; end      // R6
        else    begin kp = s;             R = g; S = r | k; end  // R5
        L = kp[0];
        case (m)
            2'b00: up = R && (S || L);         // R1
            2'b01: up = 1'b0;                  // R2
            2'b10: up = !neg && (R || S);      // R3
            default: up = neg && (R || S);     // R4
        endcase
        t = {1'b0, kp} + (up ? 1 : 0);
        e.adj = t[W];                          // R8
        e.sig = t[W] ? 24'h800000 : t[W-1:0];
        e.inx = R || S;                        // R7
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(logic [W-1:0] s, logic g, logic r, logic k,
                         logic neg, logic [1:0] m, logic sh, string tag);
        @(negedge clk);
        in_valid = 1'b1; in_sig = s; in_guard = g; in_round = r;
        in_sticky = k; in_sign = neg; in_mode = m; in_norm_shift = sh;
        sb_q.push_back(model(s, g, r, k, neg, m, sh, tag));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sig = 24'hABCDEF; in_guard = 1'b1; in_round = 1'b1;
        end
    endtask

    // Monitor / scoreboard
    always begin
        @(posedge clk);
        #1;
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R9 unexpected out_valid got=1 exp=0");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    checks++;
                    if (out_sig !== e.sig || out_exp_adj !== e.adj || out_inexact !== e.inx) begin
                        failures++;
                        $display("FAIL %s got sig=%h adj=%b inx=%b exp sig=%h adj=%b inx=%b",
                                 e.tag, out_sig, out_exp_adj, out_inexact, e.sig, e.adj, e.inx);
                    end
                end
            end else if (sb_q.size() != 0) begin
                checks++; failures++;
                void'(sb_q.pop_front());
                $display("FAIL R9 missing out_valid got=0 exp=1");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        checks++;
        if (out_valid !== 1'b0 || out_sig !== '0) begin
            failures++;
            $display("FAIL R9 reset state got valid=%b sig=%h exp valid=0 sig=000000", out_valid, out_sig);
        end

        // R1 nearest-even
        drive(24'h000001, 1, 0, 0, 0, 2'b00, 0, "R1 tie odd rounds up");
        drive(24'h000002, 1, 0, 0, 0, 2'b00, 0, "R1 tie even stays");
        drive(24'h000002, 1, 1, 0, 1, 2'b00, 0, "R1 above half rounds up");
        drive(24'h000003, 0, 1, 1, 0, 2'b00, 0, "R7 below half inexact only");
        // R2 toward zero
        drive(24'h123456, 1, 1, 1, 0, 2'b00 | 2'b01, 0, "R2 truncate");
        drive(24'hFFFFFF, 1, 1, 1, 1, 2'b01, 0, "R2 truncate all ones");
        // R3 / R4 directed
        drive(24'h800000, 0, 0, 1, 0, 2'b10, 0, "R3 positive sticky up");
        drive(24'h800000, 0, 0, 1, 1, 2'b10, 0, "R3 negative unchanged");
        drive(24'h9ABCDE, 0, 1, 0, 1, 2'b11, 0, "R4 negative up");
        drive(24'h9ABCDE, 1, 0, 0, 0, 2'b11, 0, "R4 positive unchanged");
        idle(2);
        // R5 remap without shift: round+sticky fold into S
        drive(24'h000004, 1, 0, 1, 0, 2'b00, 0, "R5 guard as R sticky from round");
        drive(24'hC00000, 0, 0, 0, 0, 2'b10, 0, "R5 exact stays");
        // R6 remap with shift
        drive(24'h400000, 1, 1, 0, 0, 2'b00, 1, "R6 shift tie odd up");
        drive(24'h400000, 0, 1, 1, 0, 2'b00, 1, "R6 shift above half up");
        drive(24'h555555, 1, 0, 0, 0, 2'b10, 1, "R6 guard becomes kept bit exact");
        idle(1);
        // R8 carry out
        drive(24'hFFFFFF, 1, 1, 0, 0, 2'b00, 0, "R8 carry unshifted");
        drive(24'hFFFFFF, 0, 0, 1, 1, 2'b11, 0, "R8 carry toward minus");
        drive(24'h7FFFFF, 1, 1, 1, 0, 2'b00, 1, "R8 carry with shift");
        drive(24'h7FFFFF, 1, 0, 1, 0, 2'b00, 1, "R6 shift below half no carry");
        idle(3);

        // mixed pseudo-random items with gaps
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[3:0] == 4'h0) idle(1);
            else drive({lfsr[31:9], lfsr[4]}, lfsr[5], lfsr[6], lfsr[7],
                       lfsr[8], lfsr[11:10], lfsr[12], "mixed R1 R9 item");
        end
        idle(3);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule